// File: doc/BRIEF.md
# Taken-Path Global History Register

This block holds a long global path history for a conditional-branch direction predictor. The history moves forward only when a branch resolves as taken. Each taken branch shifts the whole history left by one unit of two bits. A 16-bit footprint is then XORed into the low end of the shifted value. The footprint is folded from low-order bits of the branch address and the target address. The full history vector is a plain output, so the predictor's index and tag hashing can slice it as needed.

Branch events arrive on a valid/ready stream. An event is accepted in a cycle where `upd_valid` and `upd_ready` are both high. The source must hold the event steady until it is accepted. `upd_ready` is low only in a cycle where a restore is requested. A restore therefore always wins over a same-cycle event, and that event is delayed, not lost. To recover from a misprediction, the front end saves a copy of `hist` when it predicts. It later drives that copy back on `rest_hist` with `rest_en` high for one cycle. The branch address used by the footprint is the address of the last byte of the branch instruction. Only its bits 15:0 and target bits 5:0 are needed, so only those bits are ports.

Top module: `path_hist_reg`

## Requirements
- R1: `hist` is UNITS*UNIT_W bits wide (defaults: 194 units of 2 bits, 388 bits), and every bit of it can be loaded and observed.
- R2: When a taken event is accepted, the next `hist` equals the old `hist` shifted left by 2, XORed with the 16-bit footprint in bits 15:0. The top 2 bits of the old value are dropped.
- R3: Footprint bit 0 is B[3]^T[0], and footprint bit 1 is B[4]^T[1].
- R4: Footprint bits 2 to 7 are B[5] to B[10], in ascending order.
- R5: Footprint bits 8, 9 and 10 are B[0]^T[2], B[1]^T[3] and B[2]^T[4]. Footprint bit 11 is B[11]^T[5].
- R6: Footprint bits 12 to 15 are B[12] to B[15], in ascending order.
- R7: The history keeps its value in any cycle with no accepted event. It also keeps its value when the accepted event is not taken.
- R8: A synchronous reset clears `hist` to all zeros at the next clock edge.
- R9: With `rest_en` high, `hist` takes the value of `rest_hist` at the next edge, and `upd_ready` is low in that cycle. This means a same-cycle event is not applied and must be held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | Branch event present |
| upd_ready | output | 1 | Event accepted when high together with upd_valid |
| upd_taken | input | 1 | Resolved direction of the event, 1 = taken |
| upd_br_lo | input | 16 | Bits 15:0 of the last-byte address of the branch |
| upd_tgt_lo | input | 6 | Bits 5:0 of the branch target address |
| rest_en | input | 1 | Load rest_hist into the history this cycle |
| rest_hist | input | UNITS*UNIT_W | Saved history snapshot |
| hist | output | UNITS*UNIT_W | Current path history |

## Verification
The bench builds the block with 10 units of 2 bits, a 20-bit history. This is only 4 bits wider than the footprint, so bits are shifted out of the top after a few taken branches. The XOR overlap between shifted history and a new footprint is also reached quickly. A sweep drives each single branch-address bit and each single target bit from a cleared history. Each sweep step confirms where that bit lands in the footprint. A long randomized run then mixes taken, not-taken, idle, reset and restore cycles. It includes restores that collide with pending events, and it checks every cycle against an arithmetic model.

// File: rtl/phr_pkg.sv
package phr_pkg;
  localparam int FP_W  = 16;
  localparam int BLO_W = 16;
  localparam int TLO_W = 6;
  // For each footprint bit: branch-address bit it takes, and target bit
  // folded in (or -1 when none).
  localparam int BR_SEL [FP_W] = '{3, 4, 5, 6, 7, 8, 9, 10,
                                   0, 1, 2, 11, 12, 13, 14, 15};
  localparam int TG_SEL [FP_W] = '{0, 1, -1, -1, -1, -1, -1, -1,
                                   2, 3, 4, 5, -1, -1, -1, -1};
endpackage

// File: rtl/phr_footprint.sv
module phr_footprint
  import phr_pkg::*;
(
  input  logic [BLO_W-1:0] br_lo,
  input  logic [TLO_W-1:0] tgt_lo,
  output logic [FP_W-1:0]  fp
);
  for (genvar i = 0; i < FP_W; i++) begin : g_bit
    if (TG_SEL[i] >= 0) begin : g_fold
      assign fp[i] = br_lo[BR_SEL[i]] ^ tgt_lo[TG_SEL[i]];
    end else begin : g_plain
      assign fp[i] = br_lo[BR_SEL[i]];
    end
  end
endmodule

// File: rtl/phr_shift_xor.sv
module phr_shift_xor
  import phr_pkg::*;
#(
  parameter int UNITS  = 194,
  parameter int UNIT_W = 2,
  localparam int HW    = UNITS * UNIT_W,
  localparam int FP_U  = FP_W / UNIT_W
) (
  input  logic [HW-UNIT_W-1:0] keep,   // old history minus its top unit
  input  logic [FP_W-1:0]      fp,
  output logic [HW-1:0]        nxt
);
  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    if (u == 0) begin : g_low
      assign nxt[UNIT_W-1:0] = fp[UNIT_W-1:0];
    end else if (u < FP_U) begin : g_mix
      assign nxt[u*UNIT_W +: UNIT_W] =
        keep[(u-1)*UNIT_W +: UNIT_W] ^ fp[u*UNIT_W +: UNIT_W];
    end else begin : g_pass
      assign nxt[u*UNIT_W +: UNIT_W] = keep[(u-1)*UNIT_W +: UNIT_W];
    end
  end
endmodule

// File: rtl/path_hist_reg.sv
module path_hist_reg
  import phr_pkg::*;
#(
  parameter int UNITS  = 194,
  parameter int UNIT_W = 2,
  localparam int HW    = UNITS * UNIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic             upd_taken,
  input  logic [BLO_W-1:0] upd_br_lo,
  input  logic [TLO_W-1:0] upd_tgt_lo,
  input  logic             rest_en,
  input  logic [HW-1:0]    rest_hist,
  output logic [HW-1:0]    hist
);
  logic [FP_W-1:0] fp;
  logic [HW-1:0]   nxt;
  logic            fire;

  phr_footprint u_fp (
    .br_lo  (upd_br_lo),
    .tgt_lo (upd_tgt_lo),
    .fp     (fp)
  );

  phr_shift_xor #(.UNITS(UNITS), .UNIT_W(UNIT_W)) u_sx (
    .keep (hist[HW-UNIT_W-1:0]),
    .fp   (fp),
    .nxt  (nxt)
  );

  assign upd_ready = ~rest_en;
  assign fire      = upd_valid & upd_ready & upd_taken;

  always_ff @(posedge clk) begin
    if (rst)          hist <= '0;
    else if (rest_en) hist <= rest_hist;
    else if (fire)    hist <= nxt;
  end

  // R8: reset clears the history
  p_reset_clear_r8: assert property (@(posedge clk) rst |=> hist == '0);

  // R9: restore loads the snapshot
  p_restore_load_r9: assert property (@(posedge clk) disable iff (rst)
    rest_en |=> hist == $past(rest_hist));

  // R7: no accepted taken event means no change
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!rest_en && !(upd_valid && upd_ready && upd_taken)) |=> $stable(hist));

  // R2: bits above the footprint are a pure shift of the old history
  p_upper_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_ready && upd_taken)
      |=> hist[HW-1:FP_W] == $past(hist[HW-UNIT_W-1:FP_W-UNIT_W]));
endmodule

// File: tb/tb_path_hist_reg.sv
module tb_path_hist_reg;
  localparam int PERIOD = 10;
  localparam int UNITS  = 10;
  localparam int UNIT_W = 2;
  localparam int HW     = UNITS * UNIT_W;

  logic          clk = 0;
  logic          rst = 1;
  logic          upd_valid = 0, upd_taken = 0, rest_en = 0;
  logic [15:0]   upd_br_lo = '0;
  logic [5:0]    upd_tgt_lo = '0;
  logic [HW-1:0] rest_hist = '0;
  logic          upd_ready;
  logic [HW-1:0] hist;

  int n_chk = 0, n_fail = 0;
  logic [HW-1:0] model = '0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  path_hist_reg #(.UNITS(UNITS), .UNIT_W(UNIT_W)) dut (
    .clk, .rst, .upd_valid, .upd_ready, .upd_taken, .upd_br_lo,
    .upd_tgt_lo, .rest_en, .rest_hist, .hist
  );

  function automatic logic [15:0] fp_of(logic [15:0] b, logic [5:0] t);
    logic [15:0] f;
    f[0] = b[3] ^ t[0];   // R3
    f[1] = b[4] ^ t[1];   // R3
    for (int k = 2; k <= 7; k++) f[k] = b[k+3];   // R4
    f[8]  = b[0] ^ t[2];  // R5
    f[9]  = b[1] ^ t[3];
    f[10] = b[2] ^ t[4];
    f[11] = b[11] ^ t[5];
    for (int k = 12; k <= 15; k++) f[k] = b[k];    // R6
    return f;
  endfunction

  task automatic check(string tag, logic [HW-1:0] act, logic [HW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at negedge, advance one edge, compare at next negedge.
  task automatic step(bit r, bit v, bit tk, logic [15:0] b, logic [5:0] t,
                      bit re, logic [HW-1:0] rh, string tag);
    rst = r; upd_valid = v; upd_taken = tk; upd_br_lo = b; upd_tgt_lo = t;
    rest_en = re; rest_hist = rh;
    #1;
    check("R9 ready", {{(HW-1){1'b0}}, upd_ready}, {{(HW-1){1'b0}}, !re});
    if (r) model = '0;
    else if (re) model = rh;
    else if (v && tk) model = (model << 2) ^ HW'(fp_of(b, t));
    @(posedge clk);
    @(negedge clk);
    check(tag, hist, model);
  endtask

  function automatic string br_tag(int i);
    if (i == 3 || i == 4) return "R3";
    if (i >= 5 && i <= 10) return "R4";
    if (i >= 12) return "R6";
    return "R5";
  endfunction

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1, 0, 0, '0, '0, 0, '0, "R8 reset");
    // R1: every bit reachable
    step(0, 0, 0, '0, '0, 1, '1, "R1 all ones");
    step(0, 0, 0, '0, '0, 0, '0, "R7 idle hold");
    step(1, 0, 0, '0, '0, 0, '0, "R8 reset from ones");
    // Single-bit sweeps from a cleared history
    for (int i = 0; i < 16; i++) begin
      step(1, 0, 0, '0, '0, 0, '0, "R8 reset");
      step(0, 1, 1, 16'(1) << i, '0, 0, '0, br_tag(i));
    end
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 0, '0, '0, 0, '0, "R8 reset");
      step(0, 1, 1, '0, 6'(1) << i, 0, '0, (i < 2) ? "R3" : "R5");
    end
    // R2: repeated shift pushes a footprint out of the top
    step(1, 0, 0, '0, '0, 0, '0, "R8 reset");
    step(0, 1, 1, 16'h8000, '0, 0, '0, "R2 seed");
    for (int i = 0; i < 4; i++) step(0, 1, 1, '0, '0, 0, '0, "R2 shift out");
    // R7: not-taken event leaves history
    step(0, 1, 1, 16'hBEEF, 6'h2A, 0, '0, "R2 load");
    step(0, 1, 0, 16'h1234, 6'h15, 0, '0, "R7 not taken");
    // R9: restore collides with a taken event
    step(0, 1, 1, 16'hFFFF, 6'h3F, 1, 20'h5A5A5, "R9 restore priority");
    // Randomized mixed run
    for (int i = 0; i < 4000; i++) begin
      int sel = $urandom_range(0, 99);
      step(sel == 0, $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
           16'($urandom), 6'($urandom), sel >= 1 && sel <= 6, HW'($urandom),
           "R2 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule